// File: doc/BRIEF.md
# Multicycle Integer Core with Phase Skipping

This block is a small non-pipelined integer core. It handles one instruction at a time. Each instruction moves through a sequence of phases: fetch, decode, execute, memory and writeback. A controller walks through these phases and leaves out the ones an instruction has no use for. A load spends a cycle in the memory phase. Register-register and add-immediate operations go straight from execute to writeback. An unrecognised encoding stops after decode. The instruction count per cycle therefore changes with the instruction mix, while the clock only has to cover one phase.

The core holds a 32-entry register file and a word-addressed memory array that stores both program and data. The datapath has internal latches for the instruction word, the two source operands, the ALU result and the loaded word. A loader write port fills the memory, normally while reset is held.

Each retiring instruction raises `done` for exactly one cycle. A writeback shows its destination and value on the retire outputs in that same cycle.

Top module: `mcyc_core`

## Requirements
- R1: While `rst_n` is low, `pc` reads 0, `done` reads 0 and `wb_en` reads 0, and the first fetch after reset comes from word 0.
- R2: Opcode 0x08 in bits 31:26 adds register rs (bits 25:21) to the sign-extended 16-bit immediate (bits 15:0) and writes register rt (bits 20:16). It retires in exactly 4 cycles, counting its fetch cycle.
- R3: Opcode 0x23 loads the memory word at byte address rs + sign-extended immediate (word index = address bits 9:2 for the default 256-word memory) into rt. It retires in exactly 5 cycles and is the only instruction that occupies the memory phase.
- R4: Opcode 0x00 selects a register-register operation by the function field in bits 5:0: 0x20 add, 0x22 subtract (rs − rt), 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). It writes rd (bits 15:11) and always retires in exactly 4 cycles.
- R5: Any other opcode, and any opcode-0 function code not listed in R4, is a no-op. It retires after 2 cycles (fetch and decode) with `wb_en` low, and no register changes.
- R6: Register 0 always reads as zero. A writeback aimed at register 0 still shows `wb_en`, `wb_reg`=0 and the computed value on `wb_data`, but the register keeps reading zero afterwards.
- R7: `done` is high for exactly one cycle per instruction. `wb_en` is high only in that cycle, and only for instructions that write a register.
- R8: `pc` increases by 4 in every fetch cycle. During an instruction's fetch cycle, `pc` equals 4 × its word index.
- R9: Source operands are latched at the end of decode, and the instruction word is held from fetch until retirement. An instruction reading the register written by the instruction just before it sees the new value.
- R10: A loader write (`ld_we` high at a rising edge) stores `ld_data` at word `ld_addr`, and later fetches and loads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Loader write strobe |
| ld_addr | input | 8 | Loader word index |
| ld_data | input | 32 | Loader write data |
| done | output | 1 | One-cycle pulse when an instruction retires |
| wb_en | output | 1 | A register writeback happens this cycle |
| wb_reg | output | 5 | Destination register of the writeback |
| wb_data | output | 32 | Value being written back |
| pc | output | 32 | Program counter, byte address |

## Verification
The bench counts cycles from each fetch to its `done` pulse. A controller that fails to skip the memory phase would make add-immediate and register-register operations last 5 cycles. One that skips it for loads would retire a load with stale data. Negative immediates and loads through a negative offset expose a missing sign extension as a wrong value or address. Back-to-back dependent instructions and writes to register 0 catch operands taken from the wrong cycle and a register 0 that can be written. Unsupported opcodes and function codes must retire after decode with no writeback; a core that executed them would show a stray `wb_en` or a 4-cycle retire.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEM    = 3'd3,
        PH_WB     = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LOAD = 6'h23;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] res;
        logic [XLEN-1:0] mdr;
    } dp_regs_t;
endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] ent_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign ent_q[g] = '0;
        end else begin : g_store
            logic [W-1:0] val_d;
            always_comb begin
                val_d = ent_q[g];
                if (we && (wa == AW'(g))) val_d = wd;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ent_q[g] <= '0;
                else        ent_q[g] <= val_d;
            end
        end
    end

    assign rd1 = ent_q[ra1];
    assign rd2 = ent_q[ra2];
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
    import mcyc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mcyc_mem.sv
module mcyc_mem #(
    parameter int WORDS = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rd
);
    logic [W-1:0] arr [WORDS];

    always_ff @(posedge clk) begin
        if (we) arr[wa] <= wd;
    end

    assign rd = arr[ra];
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    output phase_e     phase,
    output alu_op_e    alu_op,
    output logic       use_imm,
    output logic       dst_rt,
    output logic       mem_to_reg,
    output logic       ld_ir,
    output logic       ld_opnd,
    output logic       ld_res,
    output logic       ld_mdr,
    output logic       wb_cyc,
    output logic       done
);
    typedef struct packed {
        phase_e phase;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  is_reg, fn_ok, legal, is_load;

    always_comb begin
        is_reg  = (opc == OPC_REG);
        is_load = (opc == OPC_LOAD);
        fn_ok   = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
                  (fn == FN_OR)  || (fn == FN_SLT);
        legal   = (is_reg && fn_ok) || (opc == OPC_ADDI) || is_load;

        alu_op = ALU_ADD;
        if (is_reg) begin
            unique case (fn)
                FN_SUB:  alu_op = ALU_SUB;
                FN_AND:  alu_op = ALU_AND;
                FN_OR:   alu_op = ALU_OR;
                FN_SLT:  alu_op = ALU_SLT;
                default: alu_op = ALU_ADD;
            endcase
        end
        use_imm    = !is_reg;
        dst_rt     = !is_reg;
        mem_to_reg = is_load;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.phase)
            PH_FETCH:  ctrl_d.phase = PH_DECODE;
            PH_DECODE: ctrl_d.phase = legal ? PH_EXEC : PH_FETCH;
            PH_EXEC:   ctrl_d.phase = is_load ? PH_MEM : PH_WB;
            PH_MEM:    ctrl_d.phase = PH_WB;
            PH_WB:     ctrl_d.phase = PH_FETCH;
            default:   ctrl_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{phase: PH_FETCH};
        else        ctrl_q <= ctrl_d;
    end

    assign phase   = ctrl_q.phase;
    assign ld_ir   = (ctrl_q.phase == PH_FETCH);
    assign ld_opnd = (ctrl_q.phase == PH_DECODE);
    assign ld_res  = (ctrl_q.phase == PH_EXEC);
    assign ld_mdr  = (ctrl_q.phase == PH_MEM);
    assign wb_cyc  = (ctrl_q.phase == PH_WB);
    assign done    = wb_cyc || ((ctrl_q.phase == PH_DECODE) && !legal);
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
    import mcyc_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int NREG      = 32,
    localparam int MAW      = $clog2(MEM_WORDS),
    localparam int RAW      = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we,
    input  logic [MAW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic            done,
    output logic            wb_en,
    output logic [RAW-1:0]  wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic [XLEN-1:0] pc
);
    dp_regs_t dp_d, dp_q;

    phase_e          phase;
    alu_op_e         alu_op;
    logic            use_imm, dst_rt, mem_to_reg;
    logic            ld_ir, ld_opnd, ld_res, ld_mdr, wb_cyc;
    logic [XLEN-1:0] rf_rd1, rf_rd2, alu_b, alu_y, imm_ext, mem_rd;
    logic [MAW-1:0]  mem_ra;

    mcyc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .opc        (dp_q.ir[31:26]),
        .fn         (dp_q.ir[5:0]),
        .phase      (phase),
        .alu_op     (alu_op),
        .use_imm    (use_imm),
        .dst_rt     (dst_rt),
        .mem_to_reg (mem_to_reg),
        .ld_ir      (ld_ir),
        .ld_opnd    (ld_opnd),
        .ld_res     (ld_res),
        .ld_mdr     (ld_mdr),
        .wb_cyc     (wb_cyc),
        .done       (done)
    );

    mcyc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (dp_q.ir[21+RAW-1:21]),
        .ra2   (dp_q.ir[16+RAW-1:16]),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (wb_en),
        .wa    (wb_reg),
        .wd    (wb_data)
    );

    assign imm_ext = {{(XLEN-16){dp_q.ir[15]}}, dp_q.ir[15:0]};
    assign alu_b   = use_imm ? imm_ext : dp_q.opb;

    mcyc_alu #(.W(XLEN)) u_alu (
        .op (alu_op),
        .a  (dp_q.opa),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign mem_ra = (phase == PH_MEM) ? dp_q.res[MAW+1:2] : dp_q.pc[MAW+1:2];

    mcyc_mem #(.WORDS(MEM_WORDS), .W(XLEN)) u_mem (
        .clk (clk),
        .we  (ld_we),
        .wa  (ld_addr),
        .wd  (ld_data),
        .ra  (mem_ra),
        .rd  (mem_rd)
    );

    always_comb begin
        dp_d = dp_q;
        if (ld_ir) begin
            dp_d.ir = mem_rd;
            dp_d.pc = dp_q.pc + XLEN'(4);
        end
        if (ld_opnd) begin
            dp_d.opa = rf_rd1;
            dp_d.opb = rf_rd2;
        end
        if (ld_res) dp_d.res = alu_y;
        if (ld_mdr) dp_d.mdr = mem_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign wb_en   = wb_cyc;
    assign wb_reg  = dst_rt ? dp_q.ir[16+RAW-1:16] : dp_q.ir[11+RAW-1:11];
    assign wb_data = mem_to_reg ? dp_q.mdr : dp_q.res;
    assign pc      = dp_q.pc;
endmodule

// File: rtl/mcyc_core_chk.sv
module mcyc_core_chk
    import mcyc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input phase_e      phase,
    input logic [31:0] ir,
    input logic [31:0] pc,
    input logic [31:0] opa,
    input logic [31:0] rd1,
    input logic        done,
    input logic        wb_en
);
    logic [2:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (done) cnt_q <= '0;
        else           cnt_q <= cnt_q + 3'd1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_WB_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> done); // R7
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_FETCH) |=> (pc == $past(pc) + 32'd4)); // R8
    AST_IR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (phase != PH_FETCH) |=> $stable(ir)); // R9
    AST_OPND_LATCHED: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_EXEC) |-> (opa == $past(rd1))); // R9
    AST_MEM_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_MEM) |-> (ir[31:26] == OPC_LOAD)); // R3
    AST_ADDI_LEN: assert property (@(posedge clk) disable iff (!rst_n) (done && ir[31:26] == OPC_ADDI) |-> (cnt_q == 3'd3)); // R2
    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n) (done && ir[31:26] == OPC_LOAD) |-> (cnt_q == 3'd4)); // R3
    AST_REG_LEN: assert property (@(posedge clk) disable iff (!rst_n) (wb_en && ir[31:26] == OPC_REG) |-> (cnt_q == 3'd3)); // R4
    AST_NOP_LEN: assert property (@(posedge clk) disable iff (!rst_n) (done && !wb_en) |-> (cnt_q == 3'd1)); // R5
endmodule

bind mcyc_core mcyc_core_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .ir    (dp_q.ir),
    .pc    (dp_q.pc),
    .opa   (dp_q.opa),
    .rd1   (rf_rd1),
    .done  (done),
    .wb_en (wb_en)
);

// File: tb/mcyc_core_test.sv
module mcyc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 256;
    localparam int DATA_W     = 128;
    localparam int N_RAND     = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        done, wb_en;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data, pc;

    int checks = 0;
    int errors = 0;

    logic [31:0] prog  [WORDS];
    logic [31:0] mmem  [WORDS];
    logic [31:0] mregs [32];
    int          nprog = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcyc_core uut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .done(done), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_data(wb_data), .pc(pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {opc, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic add_instr(input logic [31:0] w);
        prog[nprog] = w;
        nprog++;
    endtask

    // Reference: expected retire length, writeback flag, register and value
    task automatic model(input logic [31:0] w, output int cyc, output bit wen,
                         output int rd, output logic [31:0] val);
        logic [5:0]  opc = w[31:26];
        logic [5:0]  fn  = w[5:0];
        logic [31:0] a   = mregs[w[25:21]];
        logic [31:0] b   = mregs[w[20:16]];
        logic [31:0] ad;
        cyc = 2; wen = 0; rd = 0; val = '0;
        if (opc == 6'h08) begin
            cyc = 4; wen = 1; rd = int'(w[20:16]); val = a + sext(w[15:0]);
        end else if (opc == 6'h23) begin
            ad = a + sext(w[15:0]);
            cyc = 5; wen = 1; rd = int'(w[20:16]); val = mmem[ad[9:2]];
        end else if (opc == 6'h00) begin
            rd = int'(w[15:11]);
            wen = 1; cyc = 4;
            case (fn)
                6'h20: val = a + b;
                6'h22: val = a - b;
                6'h24: val = a & b;
                6'h25: val = a | b;
                6'h2A: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                default: begin wen = 0; cyc = 2; end
            endcase
        end
        if (wen && rd != 0) mregs[rd] = val;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int   cyc_exp, rd_exp, cycles;
        bit   wen_exp;
        logic [31:0] val_exp;
        void'($urandom(32'h5eed_1234));

        for (int i = 0; i < 32; i++) mregs[i] = '0;
        for (int i = 0; i < WORDS; i++) begin
            prog[i] = '0;
            mmem[i] = (i >= DATA_W) ? $urandom : 32'h0;
        end
        mmem[142] = 32'h8000_0003;

        // Directed prologue
        add_instr(enc_i(6'h08, 0, 1, 16'd5));         // R2
        add_instr(enc_i(6'h08, 0, 2, 16'hFFFD));      // R2 negative immediate
        add_instr(enc_i(6'h08, 1, 0, 16'd7));         // R6 write to r0
        add_instr(enc_r(0, 1, 3, 6'h20));             // R6 r0 reads zero
        add_instr(enc_r(2, 1, 4, 6'h22));             // R4 sub
        add_instr(enc_r(2, 1, 5, 6'h2A));             // R4 signed slt
        add_instr(enc_r(1, 2, 5, 6'h2A));             // R4 slt false
        add_instr(enc_i(6'h08, 0, 9, 16'h0240));
        add_instr(enc_i(6'h23, 9, 6, 16'hFFF8));      // R3 negative offset
        add_instr(enc_r(6, 6, 7, 6'h20));             // R9 back-to-back use
        add_instr(32'hFC00_0000);                     // R5 unknown opcode
        add_instr(enc_r(1, 2, 8, 6'h00));             // R5 unknown function
        add_instr(enc_r(2, 1, 10, 6'h24));            // R4 and
        add_instr(enc_r(2, 1, 11, 6'h25));            // R4 or
        add_instr(enc_r(0, 0, 12, 6'h25));            // R6 r0 reads zero

        for (int k = 0; k < N_RAND; k++) begin
            int sel = int'($urandom % 10);
            int rs  = int'($urandom % 16);
            int rt  = int'($urandom % 16);
            int rd  = int'($urandom % 16);
            if (sel < 3)
                add_instr(enc_i(6'h08, rs, rt, 16'($urandom)));
            else if (sel < 5)
                add_instr(enc_i(6'h23, 0, rt, 16'(32'h200 + 4 * ($urandom % 128))));
            else if (sel < 9) begin
                logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
                add_instr(enc_r(rs, rt, rd, fns[$urandom % 5]));
            end else
                add_instr(($urandom % 2) ? enc_i(6'h2B, rs, rt, 16'h0) : enc_r(rs, rt, rd, 6'h21));
        end

        // R10: fill memory through the loader while reset is held
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_addr = 8'(i);
            ld_data = (i < DATA_W) ? prog[i] : mmem[i];
        end
        @(negedge clk);
        ld_we = 1'b0;

        chk(pc == 32'd0, "R1", "pc in reset", pc, 32'd0);
        chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
        chk(wb_en == 1'b0, "R1", "wb_en in reset", 32'(wb_en), 32'd0);

        rst_n = 1'b1;
        for (int i = 0; i < nprog; i++) begin
            chk(pc == 32'(4 * i), "R8", "pc at fetch", pc, 32'(4 * i));
            model(prog[i], cyc_exp, wen_exp, rd_exp, val_exp);
            cycles = 0;
            forever begin
                cycles++;
                if (done || cycles > 20) break;
                @(negedge clk);
            end
            chk(cycles == cyc_exp, (cyc_exp == 5) ? "R3" : (cyc_exp == 2) ? "R5" : "R2/R4",
                "retire cycles", 32'(cycles), 32'(cyc_exp));
            chk(wb_en == wen_exp, "R7", "wb_en at done", 32'(wb_en), 32'(wen_exp));
            if (wen_exp) begin
                chk(wb_reg == 5'(rd_exp), "R4", "wb_reg", 32'(wb_reg), 32'(rd_exp));
                chk(wb_data == val_exp, (prog[i][31:26] == 6'h23) ? "R10" : "R9",
                    "wb_data", wb_data, val_exp);
            end
            @(negedge clk);
            chk(done == 1'b0, "R7", "done after retire", 32'(done), 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule